// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host side of a link to a 10-bit successive-approximation converter that has a three-wire serial port. A one-cycle `start` request makes the block drive the chip select low, which begins a conversion, while the serial clock stays low. The block then watches the data line for the rising edge that marks the end of conversion. If that edge has not come within a fixed number of system-clock cycles, the block starts clocking anyway and marks the frame as suspect.

Once clocking starts, the block produces 11 or 13 serial clock pulses, as chosen by `long_read` at start. Each data bit is captured during the high phase of its pulse. The first captured bit must be the end-of-conversion marker. The next ten bits fill the result, most significant bit first, and in a long read the two sub-bits follow. With the last falling edge the block raises the chip select and pulses `done` for one cycle. It then holds the chip select high for a minimum time before it accepts another start. After reset the block also waits a programmable wake-up interval before it accepts a request.

The controller is a Moore machine with six states. The states are ST_WAKE, ST_IDLE, ST_CONV, ST_SCLK_LO, ST_SCLK_HI and ST_CS_HOLD, and these transitions are named:
- ST_WAKE→ST_IDLE when the wake-up count expires.
- ST_IDLE→ST_CONV on `start`.
- ST_CONV→ST_SCLK_LO on a synchronized data rising edge or when the conversion count expires.
- ST_SCLK_LO→ST_SCLK_HI when the half-period expires.
- ST_SCLK_HI→ST_SCLK_LO when the half-period expires and bits remain.
- ST_SCLK_HI→ST_CS_HOLD when the half-period expires on the last bit.
- ST_CS_HOLD→ST_IDLE when the hold count expires.

All timing intervals are parameters counted in system-clock cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: For WAKE_CYC cycles after reset release, `cs_n` is 1, `sclk` is 0, `busy` is 1, `done` is 0, and `result`, `sub_bits` and `frame_err` are 0. A `start` in that window is ignored. `busy` then falls.
- R2: While idle (`busy` 0), `cs_n` is 1 and `sclk` is 0. A `start` sampled high while idle drives `cs_n` low and `busy` high in the next cycle. `sclk` stays 0 during the conversion wait.
- R3: `dout` passes through a SYNC_STAGES-flop synchronizer. A 0-to-1 step of the synchronized value during the wait ends the wait, and clocking begins with a low phase of HALF_CYC cycles.
- R4: If no such step appears within CONV_CYC cycles of `cs_n` falling, clocking begins anyway and the frame is flagged through `frame_err`.
- R5: Every low and high phase of `sclk` inside a frame lasts exactly HALF_CYC cycles, and `sclk` is 1 only while `cs_n` is 0.
- R6: A frame has 11 `sclk` pulses when `long_read` was 0 at start, and 13 pulses when it was 1.
- R7: The bit captured in the first high phase is the marker. The next ten bits go to `result[9]` down to `result[0]`. In a long read, the last two go to `sub_bits[1]` and then `sub_bits[0]`. A short read reports `sub_bits` as 2'b00.
- R8: `frame_err` is 1 when the marker bit was 0 or the wait ended by timeout (R4), and 0 otherwise.
- R9: `cs_n` rises in the same cycle as the final `sclk` falling edge. `done` is high for exactly that one cycle, with `result`, `sub_bits` and `frame_err` already updated. These outputs then hold until the next `done`.
- R10: After a frame, `cs_n` stays high for at least CSH_CYC cycles and `busy` stays high until that hold ends. A `start` while `busy` is 1 is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion-and-read frame |
| long_read | input | 1 | 1 selects the 13-pulse read that includes the sub-bits |
| busy | output | 1 | High from start (and during wake-up) until the chip-select hold ends |
| done | output | 1 | One-cycle pulse when the result outputs are valid |
| result | output | 10 | Converted value |
| sub_bits | output | 2 | Sub-bits of a long read, zero for a short read |
| frame_err | output | 1 | Timeout or missing-marker flag for the last frame |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idle low |
| dout | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with HALF_CYC = 3, CONV_CYC = 40, CSH_CYC = 5 and WAKE_CYC = 20, and keeps the default synchronizer depth and widths. These short windows make a full wake-up, an end-of-conversion timeout and a chip-select hold last only tens of cycles. A single run can therefore cover all of these paths, together with short and long reads, a marker that appears and vanishes, starts that arrive while busy, and back-to-back frames with `start` held high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_CONV,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_CS_HOLD
    } rd_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame #(
    parameter int unsigned DATA_BITS = 10,
    parameter int unsigned SUB_BITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 long_sel,
    input  logic                 sample,
    input  logic                 bit_in,
    input  logic                 timed_out,
    output logic                 last,
    output logic [DATA_BITS-1:0] result,
    output logic [SUB_BITS-1:0]  sub_bits,
    output logic                 frame_err
);
    localparam int unsigned SHORT_N = DATA_BITS + 1;
    localparam int unsigned LONG_N  = SHORT_N + SUB_BITS;
    localparam int unsigned IDX_W   = $clog2(LONG_N + 1);

    logic [IDX_W-1:0]     idx;
    logic                 long_q;
    logic                 mark_q;
    logic [DATA_BITS-1:0] data_q;
    logic [SUB_BITS-1:0]  sub_q;
    logic                 in_data;
    logic [DATA_BITS-1:0] data_nx;
    logic [SUB_BITS-1:0]  sub_nx;

    assign last    = (idx == (long_q ? IDX_W'(LONG_N - 1) : IDX_W'(SHORT_N - 1)));
    assign in_data = (idx != '0) && (idx <= IDX_W'(DATA_BITS));
    assign data_nx = DATA_BITS'({data_q, bit_in});
    assign sub_nx  = SUB_BITS'({sub_q, bit_in});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            long_q <= 1'b0;
            mark_q <= 1'b0;
            data_q <= '0;
            sub_q  <= '0;
        end else if (arm) begin
            idx    <= '0;
            long_q <= long_sel;
        end else if (sample) begin
            idx <= idx + 1'b1;
            if (idx == '0)    mark_q <= bit_in;
            else if (in_data) data_q <= data_nx;
            else              sub_q  <= sub_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            sub_bits  <= '0;
            frame_err <= 1'b0;
        end else if (sample && last) begin
            result    <= in_data ? data_nx : data_q;
            sub_bits  <= long_q ? sub_nx : '0;
            frame_err <= timed_out | ~mark_q;
        end
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_BITS   = 10,
    parameter int unsigned SUB_BITS    = 2,
    parameter int unsigned HALF_CYC    = 12,
    parameter int unsigned CONV_CYC    = 375,
    parameter int unsigned CSH_CYC     = 12,
    parameter int unsigned WAKE_CYC    = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 long_read,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] result,
    output logic [SUB_BITS-1:0]  sub_bits,
    output logic                 frame_err,
    output logic                 cs_n,
    output logic                 sclk,
    input  logic                 dout
);
    localparam int unsigned MAX_CYC = max2(max2(HALF_CYC, CONV_CYC), max2(CSH_CYC, WAKE_CYC));
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    rd_state_t     state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          frm_arm;
    logic          frm_sample;
    logic          frm_last;
    logic          fin;
    logic          ds, ds_prev, eoc_rise;
    logic          timed_out_q;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dout), .q(ds)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_prev <= 1'b0;
        else        ds_prev <= ds;
    end

    assign eoc_rise = ds & ~ds_prev;

    adc_rd_timer #(.W(TW), .RST_VAL(WAKE_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    adc_rd_frame #(.DATA_BITS(DATA_BITS), .SUB_BITS(SUB_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .arm(frm_arm), .long_sel(long_read),
        .sample(frm_sample), .bit_in(ds), .timed_out(timed_out_q),
        .last(frm_last), .result(result), .sub_bits(sub_bits), .frame_err(frame_err)
    );

    // next-state and control decode
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        frm_arm    = 1'b0;
        frm_sample = 1'b0;
        fin        = 1'b0;
        unique case (state_q)
            ST_WAKE: begin
                if (tmr_exp) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CONV_CYC - 1);
                    frm_arm  = 1'b1;
                end
            end
            ST_CONV: begin
                if (eoc_rise || tmr_exp) begin
                    state_d  = ST_SCLK_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_SCLK_LO: begin
                if (tmr_exp) begin
                    state_d  = ST_SCLK_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_SCLK_HI: begin
                if (tmr_exp) begin
                    frm_sample = 1'b1;
                    tmr_load   = 1'b1;
                    if (frm_last) begin
                        state_d = ST_CS_HOLD;
                        tmr_val = TW'(CSH_CYC - 1);
                        fin     = 1'b1;
                    end else begin
                        state_d = ST_SCLK_LO;
                        tmr_val = TW'(HALF_CYC - 1);
                    end
                end
            end
            ST_CS_HOLD: begin
                if (tmr_exp) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAKE;
        else        state_q <= state_d;
    end

    // how the conversion wait ended
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            timed_out_q <= 1'b0;
        else if (state_q == ST_CONV && (eoc_rise || tmr_exp))
            timed_out_q <= ~eoc_rise;
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
            busy <= 1'b1;
            done <= 1'b0;
        end else begin
            cs_n <= !(state_d inside {ST_CONV, ST_SCLK_LO, ST_SCLK_HI});
            sclk <= (state_d == ST_SCLK_HI);
            busy <= (state_d != ST_IDLE);
            done <= fin;
        end
    end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int unsigned HALF_CYC = 12,
    parameter int unsigned CSH_CYC  = 12
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sclk
);
    logic [31:0] sclk_run;
    logic [31:0] csh_run;
    logic        sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            sclk_run  <= 32'd0;
        end else begin
            sclk_prev <= sclk;
            if (sclk != sclk_prev)     sclk_run <= 32'd1;
            else if (sclk_run != '1)   sclk_run <= sclk_run + 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     csh_run <= 32'(CSH_CYC);
        else if (!cs_n)                 csh_run <= 32'd0;
        else if (csh_run != '1)         csh_run <= csh_run + 32'd1;
    end

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk)); // R2

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R5

    AST_SCLK_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_prev) |-> (sclk_run >= 32'(HALF_CYC))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(cs_n) && !sclk)); // R9

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start && !busy)); // R10

    AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (csh_run >= 32'(CSH_CYC))); // R10

    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.HALF_CYC(HALF_CYC), .CSH_CYC(CSH_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cs_n(cs_n), .sclk(sclk)
);

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;
    localparam int HALF = 3;
    localparam int CONV = 40;
    localparam int CSH  = 5;
    localparam int WAKE = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       long_read = 1'b0;
    logic       dout = 1'b0;
    logic       busy, done, frame_err, cs_n, sclk;
    logic [9:0] result;
    logic [1:0] sub_bits;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    adc_rd_ctrl #(.HALF_CYC(HALF), .CONV_CYC(CONV), .CSH_CYC(CSH), .WAKE_CYC(WAKE)) i_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .long_read(long_read),
        .busy(busy), .done(done), .result(result), .sub_bits(sub_bits),
        .frame_err(frame_err), .cs_n(cs_n), .sclk(sclk), .dout(dout)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // converter behaviour, updated away from the active edge
    logic [9:0] a_data = '0;
    logic [1:0] a_sub = '0;
    int         a_delay = 10;
    bit         a_glitch = 0;
    bit         a_cs_p = 1;
    bit         a_sclk_p = 0;
    int         a_cnt = 0;
    int         a_pos = 0;

    function automatic logic adc_bit(input int p);
        if (p < 10)  return a_data[9 - p];
        if (p < 12)  return a_sub[11 - p];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (cs_n) begin
            dout  <= 1'b0;
            a_cnt = 0;
            a_pos = 0;
        end else if (a_cs_p) begin
            dout  <= 1'b0;
            a_cnt = 0;
            a_pos = 0;
        end else if (a_sclk_p && !sclk) begin
            dout  <= adc_bit(a_pos);
            a_pos++;
        end else if (a_pos == 0) begin
            a_cnt++;
            if (a_cnt == a_delay) dout <= 1'b1;
            else if (a_glitch && a_cnt == a_delay + 1) dout <= 1'b0;
        end
        a_cs_p   = cs_n;
        a_sclk_p = sclk;
    end

    // behavioural reference: phase number and cycles left in it
    int         m_phase, m_left, m_bits, m_nb;
    bit         m_to, m_mark;
    logic [9:0] m_data;
    logic [1:0] m_sub;
    logic       d1, d2, dp;
    logic       e_cs, e_sclk, e_busy, e_done, e_err;
    logic [9:0] e_res;
    logic [1:0] e_sub;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = WAKE - 1; m_bits = 0; m_nb = 11;
            m_to = 0; m_mark = 0; m_data = '0; m_sub = '0;
            d1 = 0; d2 = 0; dp = 0;
            e_cs = 1; e_sclk = 0; e_busy = 1; e_done = 0; e_err = 0;
            e_res = '0; e_sub = '0;
        end else begin
            logic sb;
            bit   rise;
            sb   = d2;
            rise = d2 && !dp;
            e_done = 0;
            case (m_phase)
                0: if (m_left == 0) m_phase = 1; else m_left--;
                1: if (start) begin
                       m_phase = 2; m_left = CONV - 1; m_bits = 0;
                       m_nb = long_read ? 13 : 11;
                   end
                2: if (rise) begin m_to = 0; m_phase = 3; m_left = HALF - 1; end
                   else if (m_left == 0) begin m_to = 1; m_phase = 3; m_left = HALF - 1; end
                   else m_left--;
                3: if (m_left == 0) begin m_phase = 4; m_left = HALF - 1; end
                   else m_left--;
                4: if (m_left == 0) begin
                       if (m_bits == 0)        m_mark = sb;
                       else if (m_bits <= 10)  m_data = {m_data[8:0], sb};
                       else                    m_sub  = {m_sub[0], sb};
                       if (m_bits == m_nb - 1) begin
                           m_phase = 5; m_left = CSH - 1; e_done = 1;
                           e_res = m_data;
                           e_sub = (m_nb == 13) ? m_sub : 2'b00;
                           e_err = m_to || !m_mark;
                       end else begin
                           m_bits++; m_phase = 3; m_left = HALF - 1;
                       end
                   end else m_left--;
                default: if (m_left == 0) m_phase = 1; else m_left--;
            endcase
            e_cs   = !(m_phase == 2 || m_phase == 3 || m_phase == 4);
            e_sclk = (m_phase == 4);
            e_busy = (m_phase != 1);
            dp = d2; d2 = d1; d1 = dout;
        end
    end

    // per-cycle comparison, sampled mid-cycle
    int  pulses = 0;
    bit  sclk_seen = 0;
    bit  cs_seen = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cs_n === e_cs, "R2", "cs_n", cs_n, e_cs);
            chk(sclk === e_sclk, "R5 (R3 R4 timing)", "sclk", sclk, e_sclk);
            chk(busy === e_busy, "R10", "busy", busy, e_busy);
            chk(done === e_done, "R9", "done", done, e_done);
            chk(result === e_res, "R7", "result", result, e_res);
            chk(sub_bits === e_sub, "R7", "sub_bits", sub_bits, e_sub);
            chk(frame_err === e_err, "R8", "frame_err", frame_err, e_err);
            if (cs_seen && !cs_n) pulses = 0;
            if (sclk && !sclk_seen) pulses++;
        end
        sclk_seen = sclk;
        cs_seen   = cs_n;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic run_frame(input bit lr, input logic [9:0] d, input logic [1:0] s,
                             input int dly, input bit gl, input bit poke);
        bit exp_err;
        int guard;
        a_data = d; a_sub = s; a_delay = dly; a_glitch = gl;
        exp_err = gl || (dly > CONV);
        wait_idle();
        long_read = lr; start = 1'b1;
        @(negedge clk);
        start = 1'b0; long_read = 1'b0;
        chk(cs_n == 1'b0 && busy == 1'b1, "R2", "cs_n low after start", cs_n, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin @(negedge clk); guard++; end
        chk(result == d, "R7", "frame result", result, d);
        chk(sub_bits == (lr ? s : 2'b00), "R7", "frame sub_bits", sub_bits, lr ? s : 2'b00);
        chk(frame_err == exp_err, dly > CONV ? "R4 R8" : "R8", "frame_err", frame_err, exp_err);
        chk(pulses == (lr ? 13 : 11), "R6", "sclk pulses", pulses, lr ? 13 : 11);
        chk(cs_n == 1'b1, "R9", "cs_n high at done", cs_n, 1);
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        @(negedge clk);
        chk(cs_n == 1'b1, "R10", "no queued start", cs_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1 && cs_n == 1 && done == 0 && sclk == 0, "R1", "reset state", {busy, cs_n, done, sclk}, 4'b1100);
        chk(result == 0 && sub_bits == 0 && frame_err == 0, "R1", "reset result", result, 0);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1", "start during wake ignored", cs_n, 1);
        wait_idle();
        chk(busy == 1'b0, "R1", "busy falls after wake", busy, 0);

        run_frame(0, 10'h2A5, 2'b11, 12, 0, 0);
        run_frame(1, 10'h3FF, 2'b10, 8, 0, 0);
        run_frame(1, 10'h000, 2'b01, 25, 0, 1);
        run_frame(0, 10'h155, 2'b00, 100000, 0, 0);
        run_frame(1, 10'h0F0, 2'b11, 10, 1, 0);
        run_frame(0, 10'h001, 2'b10, 5, 0, 1);

        // back-to-back frames with start held high
        a_data = 10'h2C3; a_sub = 2'b01; a_delay = 9; a_glitch = 0;
        wait_idle();
        long_read = 1'b1; start = 1'b1;
        for (int k = 0; k < 2; k++) begin
            int guard = 0;
            @(negedge clk);
            while (!done && guard < 3000) begin @(negedge clk); guard++; end
            chk(result == 10'h2C3 && sub_bits == 2'b01, "R7", "back-to-back result", result, 10'h2C3);
        end
        start = 1'b0; long_read = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule